// File: doc/BRIEF.md
# Fuse Macro Byte Read Sequencer

This block reads a run of consecutive bytes from a one-time-programmable fuse macro. A host raises a one-cycle request carrying a start byte offset and a byte count. The sequencer wakes the macro, walks through the bytes one at a time, and pulses the macro's strobe once per byte. It captures the macro's 8-bit output at the end of each strobe and hands the byte to the host with a single-cycle valid pulse. After the last byte it parks the macro in standby and pulses `done`.

Every settling wait is a fixed number of clock cycles, set by the parameter `SETTLE_CYC` (default 100). The program-enable pin is held at its inactive level at all times, so the sequencer has no way to blow a fuse. The pin levels are also gathered into one control word for observation. In that word, chip-select is at bit 0, strobe at bit 1, load at bit 2, program-enable at bit 3 and the macro address at bits 15:6. Bits 5:4 read as zero.

Top module: `efuse_read_seq`

## Requirements
- R1: While reset is held and after it is released, the macro pins show standby: chip-select (active low) high, program-enable (active low) high, load low, strobe low, address 0. `busy`, `done` and `byteValid` are low.
- R2: The program-enable pin is high in every cycle.
- R3: In the cycle after a request with a non-zero count is accepted, chip-select goes low and load goes high. The address stays 0 and strobe stays low for `SETTLE_CYC` cycles before the first address is applied.
- R4: For each byte, the address is held for `SETTLE_CYC` cycles with strobe low. Strobe is then high for exactly `SETTLE_CYC` cycles. After strobe falls, `SETTLE_CYC` more cycles pass before the next address or standby.
- R5: The byte is sampled from the macro output in the last cycle that strobe is high. It appears on `byteData` with `byteValid` high for exactly one cycle, in the cycle in which strobe is first low again.
- R6: The macro address for byte k is (start offset + k) modulo 1024. The low 10 bits wrap from 1023 to 0, and the higher offset bits are ignored.
- R7: After the gap that follows the last byte, the pins return to the standby pattern. `done` is high for one cycle in that same cycle, and `busy` is low.
- R8: A request with a count of zero pulses `done` in the next cycle. It causes no pin change and does not raise `busy`.
- R9: A request that arrives while `busy` is high is ignored and does not alter the sequence in progress.
- R10: `ctrlWord` always equals {address, 2'b00, program-enable, load, strobe, chip-select}, with chip-select in bit 0.
- R11: `busy` is high from the cycle after acceptance up to, but not including, the cycle in which standby is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | One-cycle read request, taken only when idle |
| reqOffset | input | 16 | Start byte offset |
| reqCount | input | 8 | Number of bytes to read |
| busy | output | 1 | A read sequence is in progress |
| done | output | 1 | One-cycle pulse when the request completes |
| byteValid | output | 1 | One-cycle pulse marking a captured byte |
| byteData | output | 8 | Captured byte |
| fuseCsN | output | 1 | Macro chip-select, active low |
| fusePgmN | output | 1 | Macro program-enable, active low, held high |
| fuseLoad | output | 1 | Macro load/sense enable |
| fuseStrobe | output | 1 | Macro read strobe |
| fuseAddr | output | 10 | Macro byte address |
| fuseDout | input | 8 | Macro data output |
| ctrlWord | output | 16 | Packed view of the macro pin levels |

## Verification
The assertions check the following on every cycle:
- strobe only rises while the macro is selected and loading;
- the address does not move under a high strobe;
- each `byteValid` coincides with a strobe fall;
- `done` only appears with the pins in standby;
- `busy` tracks chip-select exactly;
- each power-up begins with address 0 and strobe low.

Other behaviours can only be shown by the bench scenarios, which compare against a cycle-timed reference:
- the exact lengths of the settling windows;
- the captured byte values;
- address wrap across 1023;
- zero-count completion;
- a request being ignored while busy.

// File: rtl/efuse_seq_pkg.sv
package efuse_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_ADDR,
    ST_STRB,
    ST_GAP
  } seqState_t;

  typedef struct packed {
    logic loadReq;
    logic enterActive;
    logic applyAddr;
    logic strobeOn;
    logic capture;
    logic advance;
    logic goStandby;
  } dpCtl_t;

endpackage

// File: rtl/efuse_seq_ctrl.sv
module efuse_seq_ctrl
  import efuse_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 100
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   countZero,
  input  logic   lastByte,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);

  localparam int TMR_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SETTLE_CYC - 1);

  seqState_t state, stateNext;
  logic [TMR_W-1:0] tmr, tmrNext;
  logic tEnd;
  logic doneNext;

  assign tEnd = (tmr == TMR_LAST);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (countZero) begin
            doneNext = 1'b1;
          end else begin
            ctl.loadReq     = 1'b1;
            ctl.enterActive = 1'b1;
            stateNext       = ST_PWR;
          end
        end
      end
      ST_PWR: begin
        if (tEnd) begin
          ctl.applyAddr = 1'b1;
          stateNext     = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (tEnd) begin
          ctl.strobeOn = 1'b1;
          stateNext    = ST_STRB;
        end
      end
      ST_STRB: begin
        if (tEnd) begin
          ctl.capture = 1'b1;
          stateNext   = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tEnd) begin
          if (lastByte) begin
            ctl.goStandby = 1'b1;
            doneNext      = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            ctl.advance = 1'b1;
            stateNext   = ST_ADDR;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state == ST_IDLE || tEnd) tmrNext = '0;
    else                          tmrNext = tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tmr   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      tmr   <= tmrNext;
      done  <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/efuse_seq_dp.sv
module efuse_seq_dp
  import efuse_seq_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int CNT_W = 8,
  parameter int FA_W  = 10,
  parameter int FD_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [FD_W-1:0]  fuseDout,
  output logic             countZero,
  output logic             lastByte,
  output logic             fuseCsN,
  output logic             fusePgmN,
  output logic             fuseLoad,
  output logic             fuseStrobe,
  output logic [FA_W-1:0]  fuseAddr,
  output logic             byteValid,
  output logic [FD_W-1:0]  byteData
);

  logic [OFS_W-1:0] offsetReg;
  logic [OFS_W-1:0] offsetInc;
  logic [CNT_W-1:0] remaining;

  assign offsetInc = offsetReg + 1'b1;
  assign countZero = (reqCount == '0);
  assign lastByte  = (remaining == CNT_W'(1));
  assign fusePgmN  = 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetReg  <= '0;
      remaining  <= '0;
      fuseCsN    <= 1'b1;
      fuseLoad   <= 1'b0;
      fuseStrobe <= 1'b0;
      fuseAddr   <= '0;
      byteValid  <= 1'b0;
      byteData   <= '0;
    end else begin
      byteValid <= ctl.capture;
      if (ctl.loadReq) begin
        offsetReg <= reqOffset;
        remaining <= reqCount;
      end
      if (ctl.enterActive) begin
        fuseCsN  <= 1'b0;
        fuseLoad <= 1'b1;
        fuseAddr <= '0;
      end
      if (ctl.applyAddr) fuseAddr <= offsetReg[FA_W-1:0];
      if (ctl.strobeOn)  fuseStrobe <= 1'b1;
      if (ctl.capture) begin
        fuseStrobe <= 1'b0;
        byteData   <= fuseDout;
      end
      if (ctl.advance) begin
        offsetReg <= offsetInc;
        remaining <= remaining - 1'b1;
        fuseAddr  <= offsetInc[FA_W-1:0];
      end
      if (ctl.goStandby) begin
        fuseCsN  <= 1'b1;
        fuseLoad <= 1'b0;
        fuseAddr <= '0;
      end
    end
  end

endmodule

// File: rtl/efuse_read_seq.sv
module efuse_read_seq
  import efuse_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int OFS_W      = 16,
  parameter int CNT_W      = 8,
  parameter int FA_W       = 10,
  parameter int FD_W       = 8,
  localparam int CW_W      = FA_W + 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [CNT_W-1:0] reqCount,
  output logic             busy,
  output logic             done,
  output logic             byteValid,
  output logic [FD_W-1:0]  byteData,
  output logic             fuseCsN,
  output logic             fusePgmN,
  output logic             fuseLoad,
  output logic             fuseStrobe,
  output logic [FA_W-1:0]  fuseAddr,
  input  logic [FD_W-1:0]  fuseDout,
  output logic [CW_W-1:0]  ctrlWord
);

  dpCtl_t ctl;
  logic countZero;
  logic lastByte;

  efuse_seq_ctrl #(
    .SETTLE_CYC(SETTLE_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .countZero(countZero),
    .lastByte (lastByte),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  efuse_seq_dp #(
    .OFS_W(OFS_W),
    .CNT_W(CNT_W),
    .FA_W (FA_W),
    .FD_W (FD_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqOffset (reqOffset),
    .reqCount  (reqCount),
    .fuseDout  (fuseDout),
    .countZero (countZero),
    .lastByte  (lastByte),
    .fuseCsN   (fuseCsN),
    .fusePgmN  (fusePgmN),
    .fuseLoad  (fuseLoad),
    .fuseStrobe(fuseStrobe),
    .fuseAddr  (fuseAddr),
    .byteValid (byteValid),
    .byteData  (byteData)
  );

  assign ctrlWord = {fuseAddr, 2'b00, fusePgmN, fuseLoad, fuseStrobe, fuseCsN};

endmodule

// File: rtl/efuse_seq_chk.sv
module efuse_seq_chk #(
  parameter int FA_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            fuseCsN,
  input logic            fuseLoad,
  input logic            fuseStrobe,
  input logic [FA_W-1:0] fuseAddr,
  input logic            byteValid,
  input logic            done,
  input logic            busy
);

  // R4: strobe only while selected and loading
  a_r4_strobe_inside_active: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |-> (!fuseCsN && fuseLoad));

  // R6: address steady while strobe stays high
  a_r6_addr_steady_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (fuseStrobe && $past(fuseStrobe)) |-> $stable(fuseAddr));

  // R5: captured byte marked exactly as strobe falls
  a_r5_valid_at_strobe_fall: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $fell(fuseStrobe));

  // R7: completion only with pins in standby
  a_r7_done_in_standby: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fuseCsN && !fuseLoad && !fuseStrobe && !busy));

  // R11: busy tracks macro selection
  a_r11_busy_means_active: assert property (@(posedge clk) disable iff (!rstN)
    busy == !fuseCsN);

  // R3: power-up starts at address 0 with strobe low
  a_r3_powerup_clean: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fuseCsN) |-> (fuseLoad && !fuseStrobe && fuseAddr == '0));

endmodule

bind efuse_read_seq efuse_seq_chk #(.FA_W(FA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .fuseCsN   (fuseCsN),
  .fuseLoad  (fuseLoad),
  .fuseStrobe(fuseStrobe),
  .fuseAddr  (fuseAddr),
  .byteValid (byteValid),
  .done      (done),
  .busy      (busy)
);

// File: tb/tb_efuse_read_seq.sv
module tb_efuse_read_seq;

  localparam int PERIOD = 10;
  localparam int S      = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqOffset = '0;
  logic [7:0]  reqCount = '0;
  logic        busy, done, byteValid;
  logic [7:0]  byteData;
  logic        fuseCsN, fusePgmN, fuseLoad, fuseStrobe;
  logic [9:0]  fuseAddr;
  logic [7:0]  fuseDout;
  logic [15:0] ctrlWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fuseVal(input logic [9:0] a);
    return a[7:0] ^ {a[9:8], 6'h2B};
  endfunction

  // behavioural fuse macro
  assign fuseDout = fuseStrobe ? fuseVal(fuseAddr) : 8'h00;

  efuse_read_seq #(.SETTLE_CYC(S)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqCount(reqCount), .busy(busy), .done(done), .byteValid(byteValid),
    .byteData(byteData), .fuseCsN(fuseCsN), .fusePgmN(fusePgmN),
    .fuseLoad(fuseLoad), .fuseStrobe(fuseStrobe), .fuseAddr(fuseAddr),
    .fuseDout(fuseDout), .ctrlWord(ctrlWord)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: mt = cycles since acceptance, -1 when idle
  int mt = -1;
  int mn = 0;
  int mstart = 0;
  bit zeroDone = 0;

  function automatic int endCyc();
    return S + 3 * S * mn;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mt = -1;
      zeroDone = 0;
    end else begin
      zeroDone = 0;
      if (mt >= 0 && mt == endCyc()) mt = -1;
      else if (mt >= 0) mt++;
      if (mt == -1 && reqValid) begin
        if (reqCount == 0) zeroDone = 1;
        else begin
          mt = 0;
          mn = int'(reqCount);
          mstart = int'(reqOffset);
        end
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    bit act, strb, vld;
    int rel, k, ph;
    logic [9:0] ea;
    act = (mt >= 0) && (mt < endCyc());
    strb = 0; vld = 0; ea = '0;
    if (act && mt >= S) begin
      rel = mt - S;
      k = rel / (3 * S);
      ph = rel % (3 * S);
      ea = 10'((mstart + k) % 1024);
      strb = (ph >= S) && (ph < 2 * S);
      vld = (ph == 2 * S);
    end
    chk("R2 pgmN", fusePgmN, 1);
    chk(act ? "R3 csN" : "R7 csN", fuseCsN, !act);
    chk(act ? "R3 load" : "R7 load", fuseLoad, act);
    chk("R4 strobe", fuseStrobe, strb);
    chk("R6 addr", fuseAddr, ea);
    chk("R5 valid", byteValid, vld);
    if (vld) chk("R5 data", byteData, fuseVal(ea));
    chk(zeroDone ? "R8 done" : "R7 done", done, (rstN && mt >= 0 && mt == endCyc()) || zeroDone);
    chk("R11 busy", busy, act);
    chk("R10 ctrlWord", ctrlWord, {ea, 2'b00, 1'b1, act, strb, !act});
  end

  task automatic issue(input logic [15:0] ofs, input logic [7:0] cnt);
    @(negedge clk);
    reqValid = 1'b1; reqOffset = ofs; reqCount = cnt;
    @(negedge clk);
    reqValid = 1'b0; reqOffset = '0; reqCount = '0;
  endtask

  task automatic waitIdle();
    while (mt >= 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: standby during and right after reset
    chk("R1 csN", fuseCsN, 1);
    chk("R1 load", fuseLoad, 0);
    chk("R1 busy", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 addr", fuseAddr, 0);
    chk("R1 strobe", fuseStrobe, 0);

    issue(16'd5, 8'd3);          // plain multi-byte read
    waitIdle();
    issue(16'd9, 8'd0);          // R8 zero count
    repeat (3) @(negedge clk);
    issue(16'd20, 8'd2);         // R9 second request while busy
    repeat (5) @(negedge clk);
    issue(16'd700, 8'd4);
    waitIdle();
    issue(16'd1022, 8'd4);       // R6 wrap 1023 -> 0
    waitIdle();
    issue(16'hABFE, 8'd3);       // R6 high offset bits ignored
    waitIdle();
    issue(16'd300, 8'd1);        // single byte
    while (mt >= 0 && mt != endCyc()) @(negedge clk);
    reqValid = 1'b1; reqOffset = 16'd40; reqCount = 8'd2;  // request in standby cycle
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule